// File: doc/BRIEF.md
# Accumulator Processor Control Sequencer

This block is the control unit of a small accumulator machine. It is a Moore state machine with sixteen states. It walks each instruction through fetch, decode and one of four execute sequences: load, store, add and conditional branch. In every state it drives a fixed set of register-transfer strobes to the datapath: clearing, incrementing and loading the program counter, loading the memory address and buffer registers, loading the instruction register and the accumulator, and the memory request together with the read or write direction. The datapath registers, the adder and the memory lie outside the block.

Memory accesses are paced by a wait line from the memory. During fetch this line is used as a two-phase handshake: the controller first waits for the line to rise, then waits for it to fall. During an operand access the controller holds while the line is high. The soft reset and the wait line each pass through one register before the next-state logic uses them, so either one acts on the state one clock after it is sampled. The two opcode bits and the accumulator sign already come from registers, so they are used without that extra register.

Top module: `acc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low, the state is RES (code 0000) and only `pc_clr` is asserted among the strobes.
- R2: A high `soft_rst`, after one synchronizing register, forces RES on the next clock from any state. RES always moves to IF0 (0001) once the synchronized reset is low.
- R3: IF0 moves to IF1 (0010). IF1 holds while the synchronized wait is low and moves to IF2 (0011) when it is high. IF2 holds while it is high and moves to IF3 (0100) when it is low. IF3 moves to OD (0101).
- R4: OD branches on `op_bits`: 00 to LD0 (0110), 01 to ST0 (1001), 10 to AD0 (1011), 11 to BR0 (1110).
- R5: LD0 moves to LD1 (0111). LD1 holds while the synchronized wait is high and moves to LD2 (1000) when it is low. LD2 returns to IF0.
- R6: AD0 moves to AD1 (1100). AD1 holds while the synchronized wait is high and moves to AD2 (1101) when it is low. AD2 returns to IF0.
- R7: ST0 moves to ST1 (1010). ST1 holds while the synchronized wait is high and returns to IF0 when it is low.
- R8: BR0 returns to IF0 when `acc_sign` is 0. It moves to BR1 (1111) when `acc_sign` is 1, and BR1 returns to IF0.
- R9: A change on `mem_wait` or `soft_rst` affects the state transition at the second rising edge after the change, not the first.
- R10: Strobes depend only on the state. RES: pc_clr. IF0: mar_from_pc, pc_inc. IF1: mem_req, mem_rd. IF2, LD1, AD1: mem_req, mem_rd, mbr_from_mem. IF3: ir_ld. LD0, AD0: mar_from_ir. ST0: mar_from_ir, mbr_from_acc. ST1: mem_req, mem_wr. LD2: ac_from_mbr. AD2: ac_add. BR1: pc_ld. OD, BR0: none.
- R11: `mem_rd` and `mem_wr` are never high together, and `mem_req` is high exactly when one of them is.
- R12: `state_o` always shows the current state code listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| soft_rst | input | 1 | Processor reset request, synchronized inside |
| mem_wait | input | 1 | Memory handshake line, synchronized inside |
| op_bits | input | 2 | Opcode field of the instruction register |
| acc_sign | input | 1 | Sign bit of the accumulator |
| pc_clr | output | 1 | Clear program counter |
| pc_inc | output | 1 | Increment program counter |
| pc_ld | output | 1 | Load program counter from instruction address field |
| mar_from_pc | output | 1 | Load address register from program counter |
| mar_from_ir | output | 1 | Load address register from instruction address field |
| mbr_from_mem | output | 1 | Load buffer register from memory data |
| mbr_from_acc | output | 1 | Load buffer register from accumulator |
| ir_ld | output | 1 | Load instruction register from buffer register |
| ac_from_mbr | output | 1 | Load accumulator from buffer register |
| ac_add | output | 1 | Load accumulator with accumulator plus buffer register |
| mem_req | output | 1 | Memory request |
| mem_rd | output | 1 | Memory read direction |
| mem_wr | output | 1 | Memory write direction |
| state_o | output | 4 | Current state code |

## Verification
Each of the four opcodes is run through a complete fetch and execute. In each fetch the wait line first stays low while IF1 holds, then rises, then falls. This separates the fetch handshake, which waits in two phases, from the single-phase operand waits. The operand accesses keep the wait line high for several cycles, which shows that LD1, AD1 and ST1 stay in place and leave only after the line falls. The branch is run with the sign bit both set and clear to tell the taken path through BR1 from the direct return. A soft reset raised in the middle of a store and the asynchronous reset raised during fetch show the one-cycle synchronizer lag and the forced return to RES.

// File: rtl/acc_ctrl_pkg.sv
package acc_ctrl_pkg;

  localparam int STATE_W = 4;
  localparam int OP_W    = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_RES = 4'b0000,
    ST_IF0 = 4'b0001,
    ST_IF1 = 4'b0010,
    ST_IF2 = 4'b0011,
    ST_IF3 = 4'b0100,
    ST_OD  = 4'b0101,
    ST_LD0 = 4'b0110,
    ST_LD1 = 4'b0111,
    ST_LD2 = 4'b1000,
    ST_ST0 = 4'b1001,
    ST_ST1 = 4'b1010,
    ST_AD0 = 4'b1011,
    ST_AD1 = 4'b1100,
    ST_AD2 = 4'b1101,
    ST_BR0 = 4'b1110,
    ST_BR1 = 4'b1111
  } ctl_state_e;

  typedef struct packed {
    logic pc_clr;
    logic pc_inc;
    logic pc_ld;
    logic mar_from_pc;
    logic mar_from_ir;
    logic mbr_from_mem;
    logic mbr_from_acc;
    logic ir_ld;
    logic ac_from_mbr;
    logic ac_add;
    logic mem_req;
    logic mem_rd;
    logic mem_wr;
  } ctl_strobe_t;

endpackage

// File: rtl/acc_ctrl_sync.sv
module acc_ctrl_sync #(
  parameter int              WIDTH  = 1,
  parameter int              STAGES = 1,
  parameter logic [WIDTH-1:0] INIT  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{INIT}};
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/acc_ctrl_next.sv
module acc_ctrl_next
  import acc_ctrl_pkg::*;
(
  input  ctl_state_e       cur,
  input  logic             sync_rst,
  input  logic             sync_wait,
  input  logic [OP_W-1:0]  op,
  input  logic             sign,
  output ctl_state_e       nxt
);

  always_comb begin
    nxt = cur;
    if (sync_rst) begin
      nxt = ST_RES;
    end else begin
      unique case (cur)
        ST_RES: nxt = ST_IF0;
        ST_IF0: nxt = ST_IF1;
        ST_IF1: nxt = sync_wait ? ST_IF2 : ST_IF1;
        ST_IF2: nxt = sync_wait ? ST_IF2 : ST_IF3;
        ST_IF3: nxt = ST_OD;
        ST_OD: begin
          unique case (op)
            2'b00:   nxt = ST_LD0;
            2'b01:   nxt = ST_ST0;
            2'b10:   nxt = ST_AD0;
            default: nxt = ST_BR0;
          endcase
        end
        ST_LD0: nxt = ST_LD1;
        ST_LD1: nxt = sync_wait ? ST_LD1 : ST_LD2;
        ST_LD2: nxt = ST_IF0;
        ST_ST0: nxt = ST_ST1;
        ST_ST1: nxt = sync_wait ? ST_ST1 : ST_IF0;
        ST_AD0: nxt = ST_AD1;
        ST_AD1: nxt = sync_wait ? ST_AD1 : ST_AD2;
        ST_AD2: nxt = ST_IF0;
        ST_BR0: nxt = sign ? ST_BR1 : ST_IF0;
        ST_BR1: nxt = ST_IF0;
        default: nxt = ST_RES;
      endcase
    end
  end

endmodule

// File: rtl/acc_ctrl_decode.sv
module acc_ctrl_decode
  import acc_ctrl_pkg::*;
(
  input  ctl_state_e  cur,
  output ctl_strobe_t strb
);

  always_comb begin
    strb = '0;
    unique case (cur)
      ST_RES: strb.pc_clr = 1'b1;
      ST_IF0: begin
        strb.mar_from_pc = 1'b1;
        strb.pc_inc      = 1'b1;
      end
      ST_IF1: begin
        strb.mem_req = 1'b1;
        strb.mem_rd  = 1'b1;
      end
      ST_IF2, ST_LD1, ST_AD1: begin
        strb.mem_req      = 1'b1;
        strb.mem_rd       = 1'b1;
        strb.mbr_from_mem = 1'b1;
      end
      ST_IF3: strb.ir_ld = 1'b1;
      ST_LD0, ST_AD0: strb.mar_from_ir = 1'b1;
      ST_ST0: begin
        strb.mar_from_ir  = 1'b1;
        strb.mbr_from_acc = 1'b1;
      end
      ST_ST1: begin
        strb.mem_req = 1'b1;
        strb.mem_wr  = 1'b1;
      end
      ST_LD2: strb.ac_from_mbr = 1'b1;
      ST_AD2: strb.ac_add = 1'b1;
      ST_BR1: strb.pc_ld = 1'b1;
      default: strb = '0;
    endcase
  end

endmodule

// File: rtl/acc_ctrl_fsm.sv
module acc_ctrl_fsm
  import acc_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               mem_wait,
  input  logic [OP_W-1:0]    op_bits,
  input  logic               acc_sign,
  output logic               pc_clr,
  output logic               pc_inc,
  output logic               pc_ld,
  output logic               mar_from_pc,
  output logic               mar_from_ir,
  output logic               mbr_from_mem,
  output logic               mbr_from_acc,
  output logic               ir_ld,
  output logic               ac_from_mbr,
  output logic               ac_add,
  output logic               mem_req,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [STATE_W-1:0] state_o
);

  logic        rst_q;
  logic        wait_q;
  ctl_state_e  st_q;
  ctl_state_e  st_d;
  ctl_strobe_t strb;

  acc_ctrl_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .INIT(1'b1)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(soft_rst), .q(rst_q)
  );

  acc_ctrl_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .INIT(1'b0)) u_wait_sync (
    .clk(clk), .rst_n(rst_n), .d(mem_wait), .q(wait_q)
  );

  acc_ctrl_next u_next (
    .cur(st_q), .sync_rst(rst_q), .sync_wait(wait_q),
    .op(op_bits), .sign(acc_sign), .nxt(st_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_RES;
    end else begin
      st_q <= st_d;
    end
  end

  acc_ctrl_decode u_decode (
    .cur(st_q), .strb(strb)
  );

  assign pc_clr       = strb.pc_clr;
  assign pc_inc       = strb.pc_inc;
  assign pc_ld        = strb.pc_ld;
  assign mar_from_pc  = strb.mar_from_pc;
  assign mar_from_ir  = strb.mar_from_ir;
  assign mbr_from_mem = strb.mbr_from_mem;
  assign mbr_from_acc = strb.mbr_from_acc;
  assign ir_ld        = strb.ir_ld;
  assign ac_from_mbr  = strb.ac_from_mbr;
  assign ac_add       = strb.ac_add;
  assign mem_req      = strb.mem_req;
  assign mem_rd       = strb.mem_rd;
  assign mem_wr       = strb.mem_wr;
  assign state_o      = st_q;

endmodule

// File: rtl/acc_ctrl_chk.sv
module acc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] st,
  input logic       rst_q,
  input logic       wait_q,
  input logic [1:0] op,
  input logic       sign,
  input logic       mbr_from_mem,
  input logic       ir_ld,
  input logic       pc_ld,
  input logic       mem_req,
  input logic       mem_rd,
  input logic       mem_wr
);

  logic [3:0] dec_target;
  always_comb begin
    case (op)
      2'b00:   dec_target = 4'b0110;
      2'b01:   dec_target = 4'b1001;
      2'b10:   dec_target = 4'b1011;
      default: dec_target = 4'b1110;
    endcase
  end

  // R2
  reset_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> (st == 4'b0000));

  // R3
  if1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'b0010 && !wait_q && !rst_q) |=> (st == 4'b0010));

  // R4
  decode_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'b0101 && !rst_q) |=> (st == $past(dec_target)));

  // R7
  store_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'b1010 && !wait_q && !rst_q) |=> (st == 4'b0001));

  // R8
  branch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pc_ld) |-> ($past(st) == 4'b1110 && $past(sign)));

  // R10
  ir_after_mbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_ld) |-> $past(mbr_from_mem));

  // R11
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R11
  req_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req == (mem_rd || mem_wr));

endmodule

bind acc_ctrl_fsm acc_ctrl_chk u_acc_ctrl_chk (
  .clk(clk), .rst_n(rst_n), .st(st_q), .rst_q(rst_q), .wait_q(wait_q),
  .op(op_bits), .sign(acc_sign), .mbr_from_mem(mbr_from_mem),
  .ir_ld(ir_ld), .pc_ld(pc_ld), .mem_req(mem_req), .mem_rd(mem_rd),
  .mem_wr(mem_wr)
);

// File: tb/test_acc_ctrl_fsm.sv
module test_acc_ctrl_fsm;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       soft_rst;
  logic       mem_wait;
  logic [1:0] op_bits;
  logic       acc_sign;
  logic       pc_clr, pc_inc, pc_ld, mar_from_pc, mar_from_ir;
  logic       mbr_from_mem, mbr_from_acc, ir_ld, ac_from_mbr, ac_add;
  logic       mem_req, mem_rd, mem_wr;
  logic [3:0] state_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  acc_ctrl_fsm i_acc_ctrl_fsm (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mem_wait(mem_wait),
    .op_bits(op_bits), .acc_sign(acc_sign), .pc_clr(pc_clr), .pc_inc(pc_inc),
    .pc_ld(pc_ld), .mar_from_pc(mar_from_pc), .mar_from_ir(mar_from_ir),
    .mbr_from_mem(mbr_from_mem), .mbr_from_acc(mbr_from_acc), .ir_ld(ir_ld),
    .ac_from_mbr(ac_from_mbr), .ac_add(ac_add), .mem_req(mem_req),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .state_o(state_o)
  );

  // Strobe order: pc_clr pc_inc pc_ld mar_pc mar_ir mbr_mem mbr_acc ir ac_mbr ac_add req rd wr
  function automatic logic [12:0] exp_strb(input logic [3:0] s);
    case (s)
      4'b0000: return 13'b1000000000000;
      4'b0001: return 13'b0101000000000;
      4'b0010: return 13'b0000000000110;
      4'b0011, 4'b0111, 4'b1100: return 13'b0000010000110;
      4'b0100: return 13'b0000000100000;
      4'b0110, 4'b1011: return 13'b0000100000000;
      4'b1001: return 13'b0000101000000;
      4'b1010: return 13'b0000000000101;
      4'b1000: return 13'b0000000010000;
      4'b1101: return 13'b0000000001000;
      4'b1111: return 13'b0010000000000;
      default: return 13'b0000000000000;
    endcase
  endfunction

  function automatic logic [12:0] act_strb();
    return {pc_clr, pc_inc, pc_ld, mar_from_pc, mar_from_ir, mbr_from_mem,
            mbr_from_acc, ir_ld, ac_from_mbr, ac_add, mem_req, mem_rd, mem_wr};
  endfunction

  task automatic check(input logic [3:0] exp_st, input string req);
    total++;
    if (state_o !== exp_st) begin
      bad++;
      $display("FAIL %s state: actual=%b expected=%b", req, state_o, exp_st);
    end
    total++;
    if (act_strb() !== exp_strb(exp_st)) begin
      bad++;
      $display("FAIL R10 strobes in %b: actual=%b expected=%b", exp_st,
               act_strb(), exp_strb(exp_st));
    end
  endtask

  task automatic cyc(input logic r, input logic w, input logic [1:0] o,
                     input logic s, input logic [3:0] exp_st, input string req);
    soft_rst = r; mem_wait = w; op_bits = o; acc_sign = s;
    @(posedge clk);
    @(negedge clk);
    check(exp_st, req);
  endtask

  // From IF0: two-phase fetch ending in OD
  task automatic fetch(input logic [1:0] o, input logic s);
    cyc(0, 0, o, s, 4'b0010, "R3");
    cyc(0, 1, o, s, 4'b0010, "R9");
    cyc(0, 1, o, s, 4'b0011, "R3");
    cyc(0, 0, o, s, 4'b0011, "R9");
    cyc(0, 0, o, s, 4'b0100, "R3");
    cyc(0, 0, o, s, 4'b0101, "R3");
  endtask

  // {soft_rst, mem_wait, op_bits, acc_sign, expected state}
  localparam logic [8:0] VEC [34] = '{
    9'b0_0_00_0_0000, 9'b0_0_00_0_0001, 9'b0_0_00_0_0010, 9'b0_1_00_0_0010,
    9'b0_1_00_0_0011, 9'b0_0_00_0_0011, 9'b0_0_00_0_0100, 9'b0_0_00_0_0101,
    9'b0_0_00_0_0110, 9'b0_1_00_0_0111, 9'b0_1_00_0_0111, 9'b0_0_00_0_0111,
    9'b0_0_00_0_1000, 9'b0_0_00_0_0001,
    9'b0_0_01_0_0010, 9'b0_1_01_0_0010, 9'b0_1_01_0_0011, 9'b0_0_01_0_0011,
    9'b0_0_01_0_0100, 9'b0_0_01_0_0101, 9'b0_0_01_0_1001, 9'b0_1_01_0_1010,
    9'b0_1_01_0_1010, 9'b0_0_01_0_1010, 9'b0_0_01_0_0001,
    9'b0_0_11_1_0010, 9'b0_1_11_1_0010, 9'b0_1_11_1_0011, 9'b0_0_11_1_0011,
    9'b0_0_11_1_0100, 9'b0_0_11_1_0101, 9'b0_0_11_1_1110, 9'b0_0_11_1_1111,
    9'b0_0_11_1_0001
  };

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b1; mem_wait = 1'b0; op_bits = 2'b00; acc_sign = 1'b0;
    repeat (3) @(negedge clk);
    check(4'b0000, "R1");
    rst_n = 1'b1;
    cyc(1, 0, 2'b00, 0, 4'b0000, "R2");
    cyc(1, 0, 2'b00, 0, 4'b0000, "R2");

    // Table: load, store and taken branch (R3 R4 R5 R7 R8 R9 R12)
    for (int i = 0; i < 34; i++) begin
      cyc(VEC[i][8], VEC[i][7], VEC[i][6:5], VEC[i][4], VEC[i][3:0], "R12");
    end

    // R6 add with long wait
    fetch(2'b10, 0);
    cyc(0, 1, 2'b10, 0, 4'b1011, "R4");
    cyc(0, 1, 2'b10, 0, 4'b1100, "R6");
    cyc(0, 1, 2'b10, 0, 4'b1100, "R6");
    cyc(0, 0, 2'b10, 0, 4'b1100, "R6");
    cyc(0, 0, 2'b10, 0, 4'b1101, "R6");
    cyc(0, 0, 2'b10, 0, 4'b0001, "R6");

    // R8 branch not taken
    fetch(2'b11, 0);
    cyc(0, 0, 2'b11, 0, 4'b1110, "R4");
    cyc(0, 0, 2'b11, 0, 4'b0001, "R8");

    // R2 soft reset in the middle of a store
    fetch(2'b01, 0);
    cyc(0, 1, 2'b01, 0, 4'b1001, "R4");
    cyc(0, 1, 2'b01, 0, 4'b1010, "R7");
    cyc(1, 1, 2'b01, 0, 4'b1010, "R9");
    cyc(0, 1, 2'b01, 0, 4'b0000, "R2");
    cyc(0, 0, 2'b01, 0, 4'b0001, "R2");

    // R1 asynchronous reset during fetch
    cyc(0, 0, 2'b00, 0, 4'b0010, "R3");
    #1 rst_n = 1'b0;
    #1 check(4'b0000, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 2'b00, 0, 4'b0000, "R2");
    cyc(0, 0, 2'b00, 0, 4'b0001, "R2");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule